// File: doc/BRIEF.md
# Processor INIT Request Generator

This block gathers every platform event that asks the processor for a soft initialization and folds them into a single active-low INIT pulse of fixed length. The events are a shutdown special cycle reported by the bus interface, decoded writes to the fast-init port (92h) and the reset-control port (CF9h) together with the written byte, and an active-low reset request from the keyboard controller.

Port writes act on bit transitions, not on levels. The block keeps its own copy of the relevant bit of each port so that writing a 1 over a 1 does nothing. The keyboard-controller request is synchronized and acts on its falling edge. After that edge fires, the path stays disarmed until the request line goes high again. While the platform is in a deep sleep state (S3 to S5), edges on that line are ignored. A reset-control write that asks for a full processor reset while the BIST enable is set produces a one-cycle BIST request flag for the reset sequencer.

Top module: `cpu_init_gen`

## Requirements
- R1: In reset and right after it, `init_n` is 1 and `bist_req` is 0. Reset clears both port bit copies to 0 and arms the keyboard path.
- R2: A cycle with `shutdown_cyc` high starts an INIT pulse. `init_n` goes low after the next clock edge.
- R3: A write to port 92h triggers INIT only when data bit 0 is 1 and the held copy of that bit is 0. Every write to 92h updates the copy, so a 1 written over a 1 does nothing.
- R4: A write to port CF9h triggers INIT only when data bit 1 is 0, data bit 2 is 1 and the held copy of bit 2 is 0. Every write to CF9h updates that copy.
- R5: After a two-stage synchronizer, a falling edge of `kbc_rst_in_n` triggers INIT when the path is armed. Each trigger disarms the path. A rising edge seen outside deep sleep re-arms it.
- R6: While `deep_sleep` is 1, edges of `kbc_rst_in_n` neither trigger INIT nor change the armed state.
- R7: `init_n` stays low for exactly 16 clocks. Triggers that arrive while it is low, including the cycle in which it returns high, are dropped. Triggers that arrive together yield one pulse.
- R8: A CF9h write with data bit 1 = 1 and a 0-to-1 change of bit 2 is a full processor reset. It raises `bist_req` for exactly one cycle when `bist_en` is 1 and does not start INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| shutdown_cyc | input | 1 | One-cycle indication of a processor shutdown special cycle |
| wr_sysctl | input | 1 | One-cycle strobe: I/O write to port 92h |
| wr_rstctl | input | 1 | One-cycle strobe: I/O write to port CF9h |
| io_wdata | input | 8 | Data byte of the decoded write |
| kbc_rst_in_n | input | 1 | Asynchronous active-low reset request from the keyboard controller |
| deep_sleep | input | 1 | High while the platform is in S3, S4 or S5 |
| bist_en | input | 1 | BIST enable bit held by configuration logic |
| init_n | output | 1 | Active-low processor INIT |
| bist_req | output | 1 | One-cycle flag: full processor reset requested with BIST enabled |

## Verification
The interesting collisions are between the pulse timer and a fresh trigger. The bench fires a shutdown cycle and a CF9h rising write in the same clock. It also re-fires a trigger in the middle of a pulse, on the exact clock where the pulse ends, and one clock later. In each case it counts low cycles of `init_n` over a fixed window: 16 in the first three cases, and 32 with a one-clock gap in the last. A second collision is between the keyboard path's arm state and the sleep indication. A rising edge during sleep followed by a falling edge after wake must produce no pulse.

// File: rtl/cpu_init_pkg.sv
package cpu_init_pkg;
  // bit positions inside the written byte; the block decodes these
  localparam int unsigned FAST_INIT_BIT = 0;  // port 92h
  localparam int unsigned FULL_RST_BIT  = 1;  // port CF9h
  localparam int unsigned CPU_RST_BIT   = 2;  // port CF9h

  localparam int unsigned DEF_PULSE_LEN   = 16;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef struct packed {
    logic soft_init;   // INIT request from a port write
    logic full_rst;    // full processor reset on CF9h
  } port_evt_t;
endpackage

// File: rtl/cig_sync.sv
module cig_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign stage_d[g] = d;
      end else begin : g_next
        assign stage_d[g] = stage_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{RESET_VAL}};
    else        stage_q <= stage_d;
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cig_port_trig.sv
module cig_port_trig
  import cpu_init_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_sysctl,
  input  logic      wr_rstctl,
  input  logic      fast_bit,
  input  logic      full_bit,
  input  logic      cpu_bit,
  input  logic      bist_en,
  output port_evt_t evt,
  output logic      bist_req
);
  logic sys_shadow_q, sys_shadow_d;
  logic cpu_shadow_q, cpu_shadow_d;
  logic bist_q, bist_d;
  logic sys_rise, cpu_rise;

  always_comb begin
    sys_rise      = wr_sysctl && fast_bit && !sys_shadow_q;
    cpu_rise      = wr_rstctl && cpu_bit && !cpu_shadow_q;
    evt.soft_init = sys_rise || (cpu_rise && !full_bit);
    evt.full_rst  = cpu_rise && full_bit;
    sys_shadow_d  = wr_sysctl ? fast_bit : sys_shadow_q;
    cpu_shadow_d  = wr_rstctl ? cpu_bit  : cpu_shadow_q;
    bist_d        = evt.full_rst && bist_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_shadow_q <= 1'b0;
      cpu_shadow_q <= 1'b0;
      bist_q       <= 1'b0;
    end else begin
      sys_shadow_q <= sys_shadow_d;
      cpu_shadow_q <= cpu_shadow_d;
      bist_q       <= bist_d;
    end
  end

  assign bist_req = bist_q;

  // R3: rewriting a one over a held one never requests INIT
  assert_sys_rewrite_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sysctl && !wr_rstctl && fast_bit && sys_shadow_q) |-> !evt.soft_init);
  // R4: the held copy follows every CF9h write
  assert_cpu_shadow_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rstctl |=> (cpu_shadow_q == $past(cpu_bit)));
  // R8: the BIST flag lasts one cycle
  assert_bist_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bist_q |=> !bist_q);
  // R8: a full reset never doubles as a soft INIT
  assert_full_not_soft_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.full_rst && !wr_sysctl) |-> !evt.soft_init);
endmodule

// File: rtl/cig_kbc_arm.sv
module cig_kbc_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic kbc_sync_n,
  input  logic deep_sleep,
  output logic kbc_trig
);
  logic prev_q, prev_d;
  logic armed_q, armed_d;
  logic fall, rise;

  always_comb begin
    fall     = prev_q && !kbc_sync_n;
    rise     = !prev_q && kbc_sync_n;
    kbc_trig = fall && armed_q && !deep_sleep;
    prev_d   = kbc_sync_n;
    armed_d  = armed_q;
    if (!deep_sleep) begin
      if (kbc_trig)  armed_d = 1'b0;
      else if (rise) armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      armed_q <= 1'b1;
    end else begin
      prev_q  <= prev_d;
      armed_q <= armed_d;
    end
  end

  // R6: nothing from this path while asleep, and the arm state holds
  assert_sleep_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    deep_sleep |-> !kbc_trig);
  assert_sleep_holds_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    deep_sleep |=> $stable(armed_q));
  // R5: a trigger leaves the path disarmed
  assert_trig_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kbc_trig |=> !armed_q);
endmodule

// File: rtl/cig_pulse.sv
module cig_pulse #(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);
  localparam int unsigned CNT_W = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_LEN - 1);

  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    if (!active_q) begin
      if (trig) begin
        active_d = 1'b1;
        cnt_d    = LOAD;
        cnt_en   = 1'b1;
      end
    end else if (cnt_q == '0) begin
      active_d = 1'b0;
    end else begin
      cnt_d  = cnt_q - CNT_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = active_q;

  // R2: an idle timer starts on any trigger
  assert_start_on_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && trig) |=> active_q);
  // R7: a running pulse counts down and is never reloaded
  assert_no_stretch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt_q != '0) |=> (active_q && cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R7: the pulse always ends from a zero count
  assert_end_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> ($past(cnt_q) == '0));
endmodule

// File: rtl/cpu_init_gen.sv
module cpu_init_gen
  import cpu_init_pkg::*;
#(
  parameter int unsigned PULSE_LEN   = DEF_PULSE_LEN,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shutdown_cyc,
  input  logic       wr_sysctl,
  input  logic       wr_rstctl,
  input  logic [7:0] io_wdata,
  input  logic       kbc_rst_in_n,
  input  logic       deep_sleep,
  input  logic       bist_en,
  output logic       init_n,
  output logic       bist_req
);
  port_evt_t port_evt;
  logic      kbc_sync_n;
  logic      kbc_trig;
  logic      any_trig;
  logic      pulse_active;
  logic      wdata_unused;

  assign wdata_unused = ^{io_wdata[7:3]};

  cig_port_trig u_port_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_sysctl (wr_sysctl),
    .wr_rstctl (wr_rstctl),
    .fast_bit  (io_wdata[FAST_INIT_BIT]),
    .full_bit  (io_wdata[FULL_RST_BIT]),
    .cpu_bit   (io_wdata[CPU_RST_BIT]),
    .bist_en   (bist_en),
    .evt       (port_evt),
    .bist_req  (bist_req)
  );

  cig_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_kbc_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (kbc_rst_in_n),
    .q     (kbc_sync_n)
  );

  cig_kbc_arm u_kbc_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .kbc_sync_n (kbc_sync_n),
    .deep_sleep (deep_sleep),
    .kbc_trig   (kbc_trig)
  );

  assign any_trig = shutdown_cyc || port_evt.soft_init || kbc_trig;

  cig_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig   (any_trig),
    .active (pulse_active)
  );

  assign init_n = !pulse_active;

  // R2: a shutdown cycle on an idle output drives INIT low next clock
  assert_shutdown_fires_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_cyc && init_n) |=> !init_n);
  // R8: the BIST flag only follows a CF9h write
  assert_bist_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bist_req |-> $past(wr_rstctl && bist_en));
endmodule

// File: tb/cpu_init_gen_bench.sv
`timescale 1ns/1ps
module cpu_init_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       shutdown_cyc, wr_sysctl, wr_rstctl;
  logic [7:0] io_wdata;
  logic       kbc_rst_in_n, deep_sleep, bist_en;
  logic       init_n, bist_req;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cpu_init_gen u_cpu_init_gen (
    .clk(clk), .rst_n(rst_n), .shutdown_cyc(shutdown_cyc),
    .wr_sysctl(wr_sysctl), .wr_rstctl(wr_rstctl), .io_wdata(io_wdata),
    .kbc_rst_in_n(kbc_rst_in_n), .deep_sleep(deep_sleep), .bist_en(bist_en),
    .init_n(init_n), .bist_req(bist_req)
  );

  // op codes: 0 idle, 1 shutdown, 2 write 92h, 3 write CF9h, 4 kbc low, 5 kbc high
  typedef struct packed {
    logic [2:0] op;
    logic [7:0] data;
    logic       bist;
    logic       sleep;
    logic [5:0] exp_low;
    logic       exp_bist;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 25;
  localparam int WIN = 24;
  localparam vec_t VECS [0:NV-1] = '{
    '{3'd2, 8'h01, 1'b0, 1'b0, 6'd16, 1'b0, 4'd3},  // R3 bit0 0->1
    '{3'd2, 8'h01, 1'b0, 1'b0, 6'd0,  1'b0, 4'd3},  // R3 one over one
    '{3'd2, 8'h00, 1'b0, 1'b0, 6'd0,  1'b0, 4'd3},
    '{3'd2, 8'h03, 1'b0, 1'b0, 6'd16, 1'b0, 4'd3},
    '{3'd1, 8'h00, 1'b0, 1'b0, 6'd16, 1'b0, 4'd2},  // R2 shutdown
    '{3'd3, 8'h04, 1'b0, 1'b0, 6'd16, 1'b0, 4'd4},  // R4 soft CPU reset
    '{3'd3, 8'h04, 1'b0, 1'b0, 6'd0,  1'b0, 4'd4},
    '{3'd3, 8'h00, 1'b0, 1'b0, 6'd0,  1'b0, 4'd4},
    '{3'd3, 8'h06, 1'b0, 1'b0, 6'd0,  1'b0, 4'd8},  // R8 full reset, no BIST
    '{3'd3, 8'h00, 1'b0, 1'b0, 6'd0,  1'b0, 4'd4},
    '{3'd3, 8'h06, 1'b1, 1'b0, 6'd0,  1'b1, 4'd8},  // R8 full reset with BIST
    '{3'd3, 8'h00, 1'b1, 1'b0, 6'd0,  1'b0, 4'd4},
    '{3'd3, 8'h04, 1'b1, 1'b0, 6'd16, 1'b0, 4'd8},  // R8 soft reset, no flag
    '{3'd4, 8'h00, 1'b0, 1'b0, 6'd16, 1'b0, 4'd5},  // R5 fall
    '{3'd5, 8'h00, 1'b0, 1'b0, 6'd0,  1'b0, 4'd5},
    '{3'd4, 8'h00, 1'b0, 1'b0, 6'd16, 1'b0, 4'd5},
    '{3'd5, 8'h00, 1'b0, 1'b0, 6'd0,  1'b0, 4'd5},
    '{3'd4, 8'h00, 1'b0, 1'b1, 6'd0,  1'b0, 4'd6},  // R6 fall in sleep
    '{3'd5, 8'h00, 1'b0, 1'b1, 6'd0,  1'b0, 4'd6},
    '{3'd4, 8'h00, 1'b0, 1'b0, 6'd16, 1'b0, 4'd6},  // still armed after sleep
    '{3'd5, 8'h00, 1'b0, 1'b1, 6'd0,  1'b0, 4'd6},  // R6 rise in sleep ignored
    '{3'd4, 8'h00, 1'b0, 1'b0, 6'd0,  1'b0, 4'd5},  // R5 disarmed
    '{3'd5, 8'h00, 1'b0, 1'b0, 6'd0,  1'b0, 4'd5},  // re-arm
    '{3'd4, 8'h00, 1'b0, 1'b0, 6'd16, 1'b0, 4'd5},
    '{3'd5, 8'h00, 1'b0, 1'b0, 6'd0,  1'b0, 4'd5}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [7:0] data);
    case (op)
      3'd1: shutdown_cyc = 1'b1;
      3'd2: begin wr_sysctl = 1'b1; io_wdata = data; end
      3'd3: begin wr_rstctl = 1'b1; io_wdata = data; end
      3'd4: kbc_rst_in_n = 1'b0;
      3'd5: kbc_rst_in_n = 1'b1;
      default: ;
    endcase
  endtask

  // count low cycles and flag cycles; re-fire shutdown at cycle 'again'
  task automatic window(input int n, input int again, output int low, output int bc);
    low = 0; bc = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (!init_n) low++;
      if (bist_req) bc++;
      if (i == 1) begin
        shutdown_cyc = 1'b0; wr_sysctl = 1'b0; wr_rstctl = 1'b0;
      end
      if (i == again + 1) shutdown_cyc = 1'b0;
      if (i == again) shutdown_cyc = 1'b1;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int low, bc;
    rst_n = 1'b0; shutdown_cyc = 1'b0; wr_sysctl = 1'b0; wr_rstctl = 1'b0;
    io_wdata = 8'h00; kbc_rst_in_n = 1'b1; deep_sleep = 1'b0; bist_en = 1'b0;
    repeat (3) @(negedge clk);
    check(init_n === 1'b1, "R1 init_n in reset", int'(init_n), 1);
    check(bist_req === 1'b0, "R1 bist_req in reset", int'(bist_req), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(init_n === 1'b1, "R1 init_n after reset", int'(init_n), 1);

    // table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      bist_en = VECS[v].bist;
      deep_sleep = VECS[v].sleep;
      apply(VECS[v].op, VECS[v].data);
      window(WIN, -5, low, bc);
      check(low == int'(VECS[v].exp_low), $sformatf("R%0d vec %0d low cycles", VECS[v].req, v),
            low, int'(VECS[v].exp_low));
      check(bc == int'(VECS[v].exp_bist), $sformatf("R%0d vec %0d bist flags", VECS[v].req, v),
            bc, int'(VECS[v].exp_bist));
    end
    bist_en = 1'b0; deep_sleep = 1'b0;

    // R7: shutdown and CF9h rising write in one clock give one pulse
    @(negedge clk); apply(3'd3, 8'h00); window(WIN, -5, low, bc);
    @(negedge clk); apply(3'd1, 8'h00); apply(3'd3, 8'h04); window(WIN, -5, low, bc);
    check(low == 16, "R7 coincident triggers", low, 16);
    @(negedge clk); apply(3'd3, 8'h04); window(WIN, -5, low, bc);
    check(low == 0, "R4 copy updated during coincidence", low, 0);

    // R7: re-trigger mid pulse does not stretch
    @(negedge clk); apply(3'd1, 8'h00); window(40, 5, low, bc);
    check(low == 16, "R7 mid-pulse retrigger", low, 16);
    // R7: trigger on the closing clock is dropped
    @(negedge clk); apply(3'd1, 8'h00); window(40, 16, low, bc);
    check(low == 16, "R7 trigger on last clock", low, 16);
    // R7: trigger one clock after the pulse starts a new one
    @(negedge clk); apply(3'd1, 8'h00); window(40, 17, low, bc);
    check(low == 32, "R7 trigger after pulse end", low, 32);

    // R1: reset clears the 92h copy
    @(negedge clk); apply(3'd2, 8'h01); window(WIN, -5, low, bc);
    check(low == 0, "R3 held one before reset", low, 0);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    apply(3'd2, 8'h01); window(WIN, -5, low, bc);
    check(low == 16, "R1 copy cleared by reset", low, 16);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule